// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter that software programs through four word registers: control/status, reload value, current value and a constant calibration word. After a reload value is written and the counter is enabled, it counts down by one on each tick of the selected time base. The time base is either every core clock cycle or a single-cycle reference pulse sampled in the core clock domain. Each time the count expires, the block sets a sticky count flag. If interrupts are enabled, it also raises a one-cycle interrupt-pend pulse toward the interrupt controller.

Reading the control word returns its contents and clears the count flag. Any write to the current-value word restarts the count from the reload value and clears the flag. A reload value of zero gives one-shot behaviour: the counter turns itself off at its first expiry.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the reload word read 0, the current word reads 0, the counter is stopped and `irqPend` is low.
- R2: The control word has enable at bit 0, interrupt enable at bit 1, time-base select at bit 2 (1 = core clock, 0 = reference pulse) and the count flag at bit 16. Every other bit reads 0. A write changes only bits [2:0], and the flag cannot be written.
- R3: While enabled, the counter advances once per core clock cycle when bit 2 is 1, and only on cycles with `refTick` high when bit 2 is 0. Expiries recur every reload+1 ticks.
- R4: Every expiry sets the count flag. `irqPend` is high for exactly one cycle per expiry, and only when bit 1 is 1.
- R5: A read of the control word returns its value and then clears the flag. If an expiry lands in the same cycle as that read, the read returns the old flag and the flag stays set.
- R6: When the reload value is 0 at an expiry, bit 0 clears and counting stops.
- R7: A write of any data to the current word (offset 0x18) reloads the counter from the reload value and clears the flag.
- R8: The current word reads the live count while enabled and reads 0 while disabled.
- R9: The reload word (offset 0x14) and the current word are 24 bits wide. Bits [31:24] read as 0, and writes to them are ignored.
- R10: Setting bit 0 from 0, or changing bit 2 while enabling, restarts the count from the reload value.
- R11: The calibration word (offset 0x1C) reads the constant `CALIB_VAL` and ignores writes. Any other address reads 0 and ignores writes. The control word sits at offset 0x10.
- R12: Read data appears on `busRdData` on the cycle after the one in which `busRdEn` is high. It reflects the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | Reference time-base pulse, one cycle wide |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| irqPend | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest situation to reach from the ports is a control-word read that falls in exactly the same cycle as an expiry. In that case the pending set of the flag must win over the clear caused by the read. The stimulus first clears the flag and starts the counter with a reload of 3 on the core-clock time base. It then places the read strobe exactly four edges after the enabling write, so that the read edge coincides with the expiry edge. A second read then shows that the flag survived. The self-disabling one-shot case and the restart on a time-base change are set up in the same deterministic way: the reference pulse is held off so that the count stays frozen at a known value.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Register byte offsets
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_RLD   = 'h14;
  localparam int OFS_CUR   = 'h18;
  localparam int OFS_CALIB = 'h1C;

  // Control word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // restart count from reload value
    logic step;  // advance one tick
  } cntStrobe_t;

endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             atZero
);

  logic [CNT_W-1:0] cntQ;

  assign atZero = (cntQ == '0);
  assign cntVal = cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= reloadVal;
    end else if (strobe.step) begin
      cntQ <= atZero ? reloadVal : cntQ - 1'b1;
    end
  end

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CALIB_VAL = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refTick,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqPend,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              ctrlEn,
  output logic              ctrlSrc,
  output logic              ctrlFlag,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              atZero
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(OFS_RLD);
  localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(OFS_CUR);
  localparam logic [ADDR_W-1:0] A_CALIB = ADDR_W'(OFS_CALIB);

  logic             enQ, ieQ, srcQ, flagQ, pendQ;
  logic [CNT_W-1:0] reloadQ;
  logic [DATA_W-1:0] rdQ;

  logic wrCtrl, wrRld, wrCur, rdCtrl;
  logic tickSel, doLoad, doStep, expire;
  logic [DATA_W-1:0] ctrlWord, rdNext;
  logic unusedWrBits;

  assign unusedWrBits = ^busWrData[DATA_W-1:CNT_W];

  assign wrCtrl = busWrEn && (busAddr == A_CTRL);
  assign wrRld  = busWrEn && (busAddr == A_RLD);
  assign wrCur  = busWrEn && (busAddr == A_CUR);
  assign rdCtrl = busRdEn && (busAddr == A_CTRL);

  // Time base selection
  assign tickSel = srcQ ? 1'b1 : refTick;

  // Restart on enable rise, on time-base change while enabling, or current write
  assign doLoad = wrCur ||
                  (wrCtrl && busWrData[BIT_EN] &&
                   (!enQ || (busWrData[BIT_SRC] != srcQ)));
  assign doStep = enQ && tickSel && !doLoad;
  assign expire = doStep && atZero;

  assign strobe.load = doLoad;
  assign strobe.step = doStep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ     <= 1'b0;
      ieQ     <= 1'b0;
      srcQ    <= 1'b0;
      reloadQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ  <= busWrData[BIT_EN];
        ieQ  <= busWrData[BIT_IE];
        srcQ <= busWrData[BIT_SRC];
      end else if (expire && (reloadQ == '0)) begin
        enQ <= 1'b0;
      end
      if (wrRld) begin
        reloadQ <= busWrData[CNT_W-1:0];
      end
    end
  end

  // Sticky flag: a new expiry wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ <= 1'b0;
    end else if (expire) begin
      flagQ <= 1'b1;
    end else if (rdCtrl || wrCur) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= 1'b0;
    end else begin
      pendQ <= expire && ieQ;
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_EN]   = enQ;
    ctrlWord[BIT_IE]   = ieQ;
    ctrlWord[BIT_SRC]  = srcQ;
    ctrlWord[BIT_FLAG] = flagQ;
  end

  always_comb begin
    unique case (busAddr)
      A_CTRL:  rdNext = ctrlWord;
      A_RLD:   rdNext = DATA_W'(reloadQ);
      A_CUR:   rdNext = enQ ? DATA_W'(cntVal) : '0;
      A_CALIB: rdNext = DATA_W'(CALIB_VAL);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdQ <= '0;
    end else if (busRdEn) begin
      rdQ <= rdNext;
    end
  end

  assign busRdData = rdQ;
  assign irqPend   = pendQ;
  assign reloadVal = reloadQ;
  assign ctrlEn    = enQ;
  assign ctrlSrc   = srcQ;
  assign ctrlFlag  = flagQ;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CALIB_VAL = 32'h0000_2710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refTick,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqPend
);

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cntVal;
  logic             atZero;
  logic             ctrlEn, ctrlSrc, ctrlFlag;

  tick_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CALIB_VAL(CALIB_VAL)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .refTick(refTick),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqPend(irqPend),
    .strobe(strobe), .reloadVal(reloadVal),
    .ctrlEn(ctrlEn), .ctrlSrc(ctrlSrc), .ctrlFlag(ctrlFlag),
    .cntVal(cntVal), .atZero(atZero)
  );

  tick_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reloadVal(reloadVal), .cntVal(cntVal), .atZero(atZero)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqPend,
  input logic              ctrlEn,
  input logic              ctrlSrc,
  input logic              ctrlFlag,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  reloadVal
);

  // R4: pend is a single-cycle pulse
  a_r4_pend_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irqPend |=> !irqPend);

  // R4: a pend is always accompanied by the sticky flag
  a_r4_pend_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irqPend |-> ctrlFlag);

  // R3: core-clock time base decrements by one each cycle
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEn && ctrlSrc && (cntVal != '0) && !busWrEn)
      |=> (cntVal == CNT_W'($past(cntVal) - 1'b1)));

  // R6: expiry with zero reload turns the counter off
  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEn && ctrlSrc && (cntVal == '0) && (reloadVal == '0) && !busWrEn)
      |=> !ctrlEn);

  // R8: current word reads 0 while disabled
  a_r8_cur_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && (busAddr == ADDR_W'(OFS_CUR)) && !ctrlEn)
      |=> (busRdData == '0));

  // R9: reload word upper bits read 0
  a_r9_rld_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && (busAddr == ADDR_W'(OFS_RLD)))
      |=> (busRdData[DATA_W-1:CNT_W] == '0));

  // R2: reserved control bits read 0
  a_r2_ctrl_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && (busAddr == ADDR_W'(OFS_CTRL)))
      |=> ((busRdData[15:3] == '0) && (busRdData[DATA_W-1:17] == '0)));

endmodule

bind tick_timer tick_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busRdData(busRdData), .irqPend(irqPend),
  .ctrlEn(ctrlEn), .ctrlSrc(ctrlSrc), .ctrlFlag(ctrlFlag),
  .cntVal(cntVal), .reloadVal(reloadVal)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CALIB = 32'h0000_2710;
  localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18,
                         A_CAL = 8'h1C;

  typedef struct packed {
    logic [23:0] rld;
    logic        src;
    logic [3:0]  gap;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{24'd3, 1'b1, 4'd0},
    '{24'd7, 1'b1, 4'd0},
    '{24'd1, 1'b1, 4'd0},
    '{24'd2, 1'b0, 4'd3},
    '{24'd5, 1'b0, 4'd2},
    '{24'd0, 1'b1, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, refTick = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic irqPend;

  int checks = 0, fails = 0, cyc = 0, refGap = 0, refPh = 0;
  bit finished = 0;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .refTick(refTick), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqPend(irqPend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(posedge clk);
    #1;
    if (refGap > 0) begin
      refPh   = (refPh + 1) % refGap;
      refTick = (refPh == 0);
    end else begin
      refTick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
  endtask

  // R12: data is taken the cycle after the strobe
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk);
    #1;
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic waitPend(output int t);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      #1;
      if (irqPend) begin
        t = cyc;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t1, t2, np;

    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check(irqPend == 1'b0, "R1 pend", {31'b0, irqPend}, 0);
    rd(A_CTRL, d); check(d == 0, "R1 ctrl", d, 0);
    rd(A_RLD, d);  check(d == 0, "R1 reload", d, 0);
    rd(A_CUR, d);  check(d == 0, "R1/R8 current", d, 0);

    // Vector table: period per time base (R3, R4)
    for (int v = 0; v < NVEC; v++) begin
      int expP;
      wr(A_CTRL, 0);
      refGap = int'(VECS[v].gap);
      expP = VECS[v].src ? int'(VECS[v].rld) + 1
                         : (int'(VECS[v].rld) + 1) * int'(VECS[v].gap);
      wr(A_RLD, {8'h00, VECS[v].rld});
      wr(A_CTRL, {29'b0, VECS[v].src, 2'b11});
      waitPend(t1);
      check(t1 >= 0, "R4 first pend", t1, 1);
      if (VECS[v].rld == 0) begin
        // R6 one-shot: no second pend, enable cleared
        np = 0;
        for (int i = 0; i < 10; i++) begin
          idle(1);
          if (irqPend) np++;
        end
        check(np == 0, "R6 no repeat", np, 0);
        rd(A_CTRL, d);
        check(d == 32'h0001_0006, "R6 self disable", d, 32'h0001_0006);
        rd(A_CUR, d); check(d == 0, "R8 current after stop", d, 0);
      end else begin
        waitPend(t2);
        check((t2 - t1) == expP, "R3 period", t2 - t1, expP);
      end
    end
    refGap = 0;

    // R2 control write masking
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, d); check(d == 0, "R2 upper write ignored", d, 0);
    wr(A_CTRL, 32'h0000_0006);
    rd(A_CTRL, d); check(d == 32'h6, "R2 bits", d, 32'h6);
    wr(A_CTRL, 0);

    // R9 width
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, d); check(d == 32'h00FF_FFFF, "R9 reload all ones", d, 32'h00FF_FFFF);
    wr(A_RLD, 32'hAB00_0005);
    rd(A_RLD, d); check(d == 32'h5, "R9 reload upper ignored", d, 32'h5);

    // R4/R5 flag without interrupt enable
    wr(A_RLD, 3);
    wr(A_CTRL, 32'h5);
    np = 0;
    for (int i = 0; i < 6; i++) begin
      idle(1);
      if (irqPend) np++;
    end
    check(np == 0, "R4 no pend when disabled", np, 0);
    rd(A_CTRL, d); check(d == 32'h0001_0005, "R5 flag set", d, 32'h0001_0005);
    rd(A_CTRL, d); check(d == 32'h5, "R5 flag cleared by read", d, 32'h5);

    // R5 coincident read and expiry
    wr(A_CTRL, 0);
    rd(A_CTRL, d);
    wr(A_CTRL, 32'h5);
    idle(3);
    rd(A_CTRL, d); check(d == 32'h5, "R5 read at expiry old value", d, 32'h5);
    rd(A_CTRL, d); check(d == 32'h0001_0005, "R5 flag survives", d, 32'h0001_0005);

    // R7 current write reloads and clears flag
    wr(A_CTRL, 0);
    wr(A_RLD, 2);
    wr(A_CTRL, 32'h5);
    idle(5);
    wr(A_RLD, 100);
    wr(A_CUR, 32'h1234_5678);
    rd(A_CUR, d);  check(d == 100, "R7 reload on current write", d, 100);
    rd(A_CTRL, d); check(d == 32'h5, "R7 flag cleared", d, 32'h5);
    rd(A_CUR, d);  check(d == 98, "R8 live count", d, 98);

    // R8 disabled read
    wr(A_CTRL, 0);
    rd(A_CUR, d); check(d == 0, "R8 disabled reads 0", d, 0);

    // R10 time-base change restarts; R3 no ref pulses, no counting
    wr(A_RLD, 50);
    wr(A_CTRL, 32'h5);
    idle(20);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, d); check(d == 50, "R10 restart on source change", d, 50);
    idle(10);
    rd(A_CUR, d); check(d == 50, "R3 held without ref pulse", d, 50);

    // R11 calibration and unmapped
    rd(A_CAL, d); check(d == CALIB, "R11 calibration", d, CALIB);
    wr(A_CAL, 32'hDEAD_BEEF);
    rd(A_CAL, d); check(d == CALIB, "R11 calibration write ignored", d, CALIB);
    rd(8'h20, d); check(d == 0, "R11 unmapped read", d, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check(d == 32'h1, "R11 unmapped write ctrl", d, 32'h1);
    rd(A_RLD, d);  check(d == 50, "R11 unmapped write reload", d, 50);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule